// File: doc/BRIEF.md
# Eight-bit timer/counter with shared prescaler

This block keeps an 8-bit count that software can load at any time and read continuously. In timer mode it advances on the instruction-cycle strobe. In counter mode it advances on edges of an outside signal. That signal is either an input pin or a comparator output. It passes through a strobe-clocked synchronizer, and a configuration bit chooses whether rising or falling edges count.

One power-of-two prescaler belongs to exactly one client at a time. When it serves the count, the count advances once per 2 to 256 source events. When it serves the watchdog, it divides the instruction strobe into a watchdog tick, and the count takes every source event directly.

Loading the count resets the prescaler when the prescaler serves the count. The load also starts a two-strobe freeze. When the count wraps from 0xFF to 0x00, the block raises a one-cycle flag.

Top module: `tmr8_core`

## Requirements
- R1: While rst_ni is low, count_o is 0x00 and ovf_o and wdt_tick_o are 0.
- R2: The count changes only on a clock edge where cyc_en_i or wr_en_i is high. With mode_cnt_i=0 and psa_wdt_i=1, it rises by exactly one per strobe.
- R3: When wr_en_i is high on an edge, count_o takes wr_data_i on that edge, even if a strobe or increment falls on the same edge. The next two strobes after the write advance neither the count nor the prescaler, and source events on those strobes are lost.
- R4: With psa_wdt_i=0, the count advances once every 2^(ps_rate_i+1) accepted source events. A write clears the prescaler, so after a write and its two frozen strobes, N further events give floor(N / 2^(ps_rate_i+1)).
- R5: With mode_cnt_i=1, src_sel_i=0 picks ext_pin_i and src_sel_i=1 picks cmp_out_i. Transitions on the input that is not selected leave the count unchanged.
- R6: edge_fall_i=0 counts low-to-high transitions of the selected source. edge_fall_i=1 counts high-to-low transitions.
- R7: Suppose a counted transition is applied between two strobes. The count does not move on the first or second strobe after it, and moves on the third.
- R8: With psa_wdt_i=1, wdt_tick_o pulses once every 2^(ps_rate_i+1) strobes, and each pulse is aligned with a strobe. With psa_wdt_i=0, wdt_tick_o stays 0.
- R9: When an increment takes the count from 0xFF to 0x00, ovf_o is high for exactly the one clock cycle following that edge, while count_o reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle strobe, one clock wide |
| wr_en_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 8 | Value to load |
| ext_pin_i | input | 1 | External clock pin |
| cmp_out_i | input | 1 | Comparator output |
| mode_cnt_i | input | 1 | 0 = timer mode, 1 = counter mode |
| src_sel_i | input | 1 | Counter source: 0 = pin, 1 = comparator |
| edge_fall_i | input | 1 | 0 = rising edge, 1 = falling edge |
| psa_wdt_i | input | 1 | Prescaler owner: 0 = count, 1 = watchdog |
| ps_rate_i | input | 3 | Prescale exponent minus one |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | Wrap flag, one cycle |
| wdt_tick_o | output | 1 | Prescaled tick for the watchdog |

## Verification
Two things can land on the same strobe: a software load of the count, and an increment from the timer or from a synchronized edge. The bench issues loads without aligning them to the strobe. It also loads during a prescale run and in counter mode while edges are still in the synchronizer.

The result is judged by counting strobes after the load. It must equal the loaded value plus the events accepted after exactly two frozen strobes. For a prescaled run, it is that event count divided by the ratio, with the prescaler restarting from zero at the load.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int CNT_W      = 8;
  localparam int RATE_W     = 3;
  localparam int HOLD_CYC   = 2;
  localparam int SYNC_DEPTH = 3;
endpackage

// File: rtl/tmr8_src_sync.sv
module tmr8_src_sync
  import tmr8_pkg::*;
#(
  parameter int DEPTH = SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  input  logic pin_i,
  input  logic cmp_i,
  input  logic src_sel_i,
  input  logic edge_fall_i,
  output logic evt_o
);
  logic             raw;
  logic [DEPTH-1:0] sh_q;

  // polarity folded in so only rising edges are detected downstream
  assign raw = (src_sel_i ? cmp_i : pin_i) ^ edge_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (cyc_en_i) sh_q <= {sh_q[DEPTH-2:0], raw};
  end

  assign evt_o = cyc_en_i & sh_q[DEPTH-2] & ~sh_q[DEPTH-1];

  p_evt_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int RW = RATE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          evt_i,
  input  logic [RW-1:0] rate_i,
  output logic          tick_o
);
  localparam int PW = 2 ** RW;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (i <= int'(rate_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (evt_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = evt_i & ~clr_i & ((cnt_q | ~mask) == '1);

  p_tick_spaced_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr8_cnt_reg.sv
module tmr8_cnt_reg
  import tmr8_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int HOLD = HOLD_CYC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_en_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o,
  output logic         hold_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold_q;
  logic [W-1:0]  cnt_q;
  logic          ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_en_i) begin
        cnt_q  <= wr_data_i;
        hold_q <= HW'(HOLD);
      end else begin
        if (cyc_en_i && hold_q != '0) hold_q <= hold_q - 1'b1;
        if (inc_i) begin
          cnt_q <= cnt_q + 1'b1;
          ovf_q <= (cnt_q == '1);
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign hold_o  = (hold_q != '0);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0 && !wr_en_i) |=> $stable(cnt_q));
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_en_i && !wr_en_i) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  p_ovf_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_q == '0));
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int RW = RATE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_en_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          ext_pin_i,
  input  logic          cmp_out_i,
  input  logic          mode_cnt_i,
  input  logic          src_sel_i,
  input  logic          edge_fall_i,
  input  logic          psa_wdt_i,
  input  logic [RW-1:0] ps_rate_i,
  output logic [W-1:0]  count_o,
  output logic          ovf_o,
  output logic          wdt_tick_o
);
  logic src_evt, base_ok, ps_in, ps_tick, inc, hold;

  tmr8_src_sync i_sync (
    .clk_i, .rst_ni, .cyc_en_i,
    .pin_i(ext_pin_i), .cmp_i(cmp_out_i),
    .src_sel_i, .edge_fall_i,
    .evt_o(src_evt)
  );

  // events on frozen strobes or on a write edge are dropped entirely
  assign base_ok = (mode_cnt_i ? src_evt : cyc_en_i) & ~hold & ~wr_en_i;
  assign ps_in   = psa_wdt_i ? cyc_en_i : base_ok;

  tmr8_prescaler #(.RW(RW)) i_ps (
    .clk_i, .rst_ni,
    .clr_i(wr_en_i & ~psa_wdt_i),
    .evt_i(ps_in), .rate_i(ps_rate_i),
    .tick_o(ps_tick)
  );

  assign inc        = psa_wdt_i ? base_ok : ps_tick;
  assign wdt_tick_o = psa_wdt_i & ps_tick;

  tmr8_cnt_reg #(.W(W)) i_cnt (
    .clk_i, .rst_ni, .cyc_en_i, .wr_en_i, .wr_data_i,
    .inc_i(inc), .count_o, .ovf_o, .hold_o(hold)
  );

  p_wdt_on_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tick_o |-> cyc_en_i);
endmodule

// File: tb/test_tmr8_core.sv
module test_tmr8_core;
  logic       clk = 0, rst_n = 0;
  logic [1:0] div;
  logic       cyc_en, wr_en = 0, pin = 0, cmp = 0;
  logic       mode = 0, srcs = 0, efall = 0, psa = 1;
  logic [7:0] wdata = 0;
  logic [2:0] rate = 0;
  logic [7:0] count;
  logic       ovf, wtick;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) div <= 0; else div <= div + 2'd1;
  assign cyc_en = rst_n && div == 2'd3;

  tmr8_core i_tmr8_core (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .wr_en_i(wr_en),
    .wr_data_i(wdata), .ext_pin_i(pin), .cmp_out_i(cmp), .mode_cnt_i(mode),
    .src_sel_i(srcs), .edge_fall_i(efall), .psa_wdt_i(psa), .ps_rate_i(rate),
    .count_o(count), .ovf_o(ovf), .wdt_tick_o(wtick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the next strobe edge
  task automatic strobe();
    while (!cyc_en) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic wr(input logic [7:0] v);
    wdata = v; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input bit on_cmp);
    if (on_cmp) cmp = 1; else pin = 1;
    strobes(3);
    if (on_cmp) cmp = 0; else pin = 0;
    strobes(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    chk(count == 0 && !ovf && !wtick, "R1", count, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: timer 1:1, write freeze
    psa = 1; mode = 0;
    wr(8'h40);
    chk(count == 8'h40, "R3 load", count, 8'h40);
    strobes(2);
    chk(count == 8'h40, "R3 frozen", count, 8'h40);
    strobe();
    chk(count == 8'h41, "R3 resume", count, 8'h41);
    strobes(10);
    chk(count == 8'h4b, "R2 one per strobe", count, 8'h4b);
    repeat (2) @(negedge clk);
    if (!cyc_en) begin
      @(negedge clk);
      chk(count == 8'h4b, "R2 no strobe", count, 8'h4b);
    end

    // R9: wrap
    wr(8'hFD);
    strobes(4);
    chk(count == 8'hFF && !ovf, "R9 pre", count, 8'hFF);
    strobe();
    chk(count == 0 && ovf, "R9 flag", {ovf, count}, 256);
    @(negedge clk);
    chk(!ovf, "R9 single cycle", ovf, 0);

    // R4: prescale sweep in timer mode
    psa = 0;
    for (int r = 0; r < 8; r++) begin
      int l;
      l = 1 << (r + 1);
      rate = 3'(r);
      wr(8'h00);
      strobes(2 + l - 1);
      chk(count == 0, "R4 before ratio", count, 0);
      strobe();
      chk(count == 1, "R4 at ratio", count, 1);
      strobes(2 * l + 1);
      chk(count == 3, "R4 three periods", count, 3);
    end

    // R8: tick idle while prescaler serves count
    ticks = 0;
    for (int i = 0; i < 32; i++) begin
      while (!cyc_en) @(negedge clk);
      if (wtick) ticks++;
      @(negedge clk);
    end
    chk(ticks == 0, "R8 idle", ticks, 0);

    // R8: watchdog tick ratio
    psa = 1;
    for (int r = 0; r < 4; r++) begin
      rate = 3'(r);
      ticks = 0;
      for (int i = 0; i < 4 * (1 << (r + 1)); i++) begin
        while (!cyc_en) @(negedge clk);
        if (wtick) ticks++;
        @(negedge clk);
      end
      chk(ticks == 4, "R8 ratio", ticks, 4);
    end

    // R6/R7: counter mode, pin, rising
    mode = 1; srcs = 0; efall = 0; psa = 1;
    strobes(4); wr(8'h00); strobes(2);
    pin = 1;
    strobes(2);
    chk(count == 0, "R7 latency early", count, 0);
    strobe();
    chk(count == 1, "R7 third strobe", count, 1);
    pin = 0; strobes(3);
    chk(count == 1, "R6 rising ignores fall", count, 1);
    for (int i = 0; i < 4; i++) pulse(0);
    chk(count == 5, "R5 pin pulses", count, 5);
    for (int i = 0; i < 3; i++) pulse(1);
    chk(count == 5, "R5 comparator ignored", count, 5);

    // R6: falling edge
    efall = 1;
    strobes(4); wr(8'h00); strobes(2);
    pin = 1; strobes(3);
    chk(count == 0, "R6 falling ignores rise", count, 0);
    pin = 0; strobes(2);
    chk(count == 0, "R6 falling latency", count, 0);
    strobe();
    chk(count == 1, "R6 falling counted", count, 1);

    // R5: comparator source
    efall = 0; srcs = 1;
    strobes(4); wr(8'h10); strobes(2);
    for (int i = 0; i < 4; i++) pulse(1);
    for (int i = 0; i < 2; i++) pulse(0);
    chk(count == 8'h14, "R5 comparator", count, 8'h14);

    // R4: prescaler in counter mode, 1:2
    psa = 0; rate = 0;
    wr(8'h00); strobes(2);
    for (int i = 0; i < 6; i++) pulse(1);
    chk(count == 3, "R4 counter prescale", count, 3);

    // R3: write while an edge sits in the synchronizer
    psa = 1;
    cmp = 1; strobe();
    wr(8'h80);
    strobes(6);
    chk(count == 8'h80, "R3 edge lost in freeze", count, 8'h80);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule